// File: doc/BRIEF.md
# Auto-Reload Up-Counting Timer Core

This block is the counting core of a general-purpose interval timer. A counter as wide as `CNT_W` climbs by one on every cycle where it is running and the external tick enable is high. When it equals the active reload value on such a tick, it returns to zero and raises an update event. Each update event sets a sticky update flag, and the flag drives an interrupt line when the interrupt mask allows it. The core has no prescaler. The tick enable is the only way to slow it down.

A register interface in front of the core decodes bus accesses into single-cycle strobes and level controls. Writes to the reload value go either straight into the active reload register or into a holding register that is copied across only at an update event. The update-disable control blocks every update source. The overflow-only control blocks software-forced updates but leaves overflow updates in place. A software update request is taken in one cycle and carried out in the next. A completion bit drops when the request arrives and comes back one cycle after the request is carried out. Start and stop strobes set the run state. Software reads the run state and whether the counter is actually advancing.

Top module: `reload_tick_timer`

## Requirements
- R1: While `run_status` is 1 and `tick_en` is 1, and there is no counter write and no software update being applied, `cnt_val` goes up by one on each clock unless it equals `reload_active`. When `tick_en` is 0, or the block is stopped, the counter holds its value.
- R2: A tick taken while `cnt_val` equals `reload_active` sets the counter to 0 on the next cycle. When updates are not disabled, `upd_evt` is 1 during the cycle of that tick. This also holds when the reload value is all ones.
- R3: With `preload_en` at 0, a `reload_wr` strobe loads `reload_wdata` into both `reload_preload` and `reload_active` on the next cycle. With `preload_en` at 1, the strobe loads only `reload_preload`, and `reload_active` takes the held value at the next update event.
- R4: While `upd_dis` is 1, no update event occurs from any source and `reload_active` receives no transfer. A matching overflow still sets the counter to 0, and a software request leaves the counter and the flag unchanged.
- R5: A `ug_req` strobe sets `ug_busy` for exactly one cycle, and during that cycle `upd_evt` is 1. At the end of that cycle the counter is cleared and the update takes effect. When `ovf_only` is 1, the request produces no update event and does not clear the counter.
- R6: Every update event sets `upd_flag` on the next cycle. A `flag_clr` strobe clears it, and a new event in the same cycle takes priority over the clear.
- R7: `irq` is 1 exactly when `upd_flag` and `irq_en` are both 1.
- R8: `ug_done` is 1 after reset. It becomes 0 on the cycle after an accepted `ug_req` and becomes 1 again one cycle after `ug_busy` falls, whether or not the request produced an event.
- R9: After reset, `cnt_val` is 0, both reload registers are all ones, and `upd_flag`, `run_status`, `ug_busy` and `irq` are 0.
- R10: `start_req` sets `run_status` and `stop_req` clears it, with stop taking priority when both are given. `working_status` is 1 only while the block is running and `tick_en` is 1.
- R11: A `cnt_wr` strobe loads `cnt_wdata` into the counter on the next cycle, even while the block is running, and it takes priority over counting. An effective software update applied in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count qualifier; the counter advances only when this is high |
| start_req | input | 1 | Strobe that sets the run state |
| stop_req | input | 1 | Strobe that clears the run state |
| preload_en | input | 1 | 1: reload writes are held until an update event |
| upd_dis | input | 1 | 1: all update events are blocked |
| ovf_only | input | 1 | 1: only overflow counts as an update source |
| irq_en | input | 1 | Interrupt mask for the update flag |
| ug_req | input | 1 | Strobe requesting a software update |
| flag_clr | input | 1 | Strobe clearing the update flag |
| reload_wr | input | 1 | Strobe writing the reload value |
| reload_wdata | input | CNT_W | Reload write data |
| cnt_wr | input | 1 | Strobe writing the counter |
| cnt_wdata | input | CNT_W | Counter write data |
| cnt_val | output | CNT_W | Current counter value |
| reload_preload | output | CNT_W | Reload value as software reads it back |
| reload_active | output | CNT_W | Reload value the comparison is using |
| run_status | output | 1 | Applied run state |
| working_status | output | 1 | Counter is advancing this cycle |
| ug_busy | output | 1 | Software update accepted and not yet applied |
| ug_done | output | 1 | Software update completion status |
| upd_flag | output | 1 | Sticky update flag |
| upd_evt | output | 1 | Update event occurring this cycle |
| irq | output | 1 | Masked update interrupt |

## Verification
The hardest cases to reach are the ones where several sources hit the counter in the same cycle. One is a software update being applied while a counter write is also pending. The other is a matching overflow while update-disable is set and a different value is waiting in the holding register. The stimulus stops the counter and places it with direct writes. It then restarts the counter a known number of cycles before the compare match, so that the overflow edge falls on a predicted cycle. For the collision, a counter write is issued on the exact cycle when the update request is busy. The stimulus also runs a wrap at the all-ones reload value to cover the top edge of the counter width.

// File: rtl/rtt_pkg.sv
`timescale 1ns/1ps
package rtt_pkg;

   // Update-event sources, ordered by their weight in the counter path.
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_OVF  = 2'd1,
      SRC_SW   = 2'd2
   } rtt_src_e;

   // Level controls presented by the register front end.
   typedef struct packed {
      logic preload_en;
      logic upd_dis;
      logic ovf_only;
   } rtt_ctrl_t;

   localparam int unsigned RTT_MIN_W = 2;
   localparam int unsigned RTT_MAX_W = 64;

endpackage

// File: rtl/rtt_runctl.sv
`timescale 1ns/1ps
module rtt_runctl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic stop_req,
   input  logic tick_en,
   output logic run_q,
   output logic step
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (stop_req) begin
         run_q <= 1'b0;
      end else if (start_req) begin
         run_q <= 1'b1;
      end
   end

   assign step = run_q & tick_en;

endmodule

// File: rtl/rtt_swupd.sv
`timescale 1ns/1ps
module rtt_swupd (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy_q,
   output logic done_q
);

   logic applied_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         applied_q <= 1'b0;
         done_q    <= 1'b1;
      end else begin
         applied_q <= busy_q;
         if (busy_q) begin
            busy_q <= 1'b0;
         end else begin
            busy_q <= req;
         end
         if (req && !busy_q) begin
            done_q <= 1'b0;
         end else if (applied_q) begin
            done_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/rtt_reload.sv
`timescale 1ns/1ps
module rtt_reload #(
   parameter int unsigned     W        = 32,
   parameter logic [W-1:0]    INIT     = '1,
   parameter bit              BUFFERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         preload_en,
   input  logic         xfer,
   output logic [W-1:0] preload_q,
   output logic [W-1:0] active_q
);

   generate
      if (BUFFERED) begin : g_buffered
         logic [W-1:0] hold_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= INIT;
            end else if (wr) begin
               hold_q <= wdata;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               active_q <= INIT;
            end else if (wr && !preload_en) begin
               active_q <= wdata;
            end else if (xfer) begin
               active_q <= hold_q;
            end
         end

         assign preload_q = hold_q;
      end else begin : g_direct
         logic unused_preload_en;
         logic unused_xfer;

         assign unused_preload_en = preload_en;
         assign unused_xfer       = xfer;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               active_q <= INIT;
            end else if (wr) begin
               active_q <= wdata;
            end
         end

         assign preload_q = active_q;
      end
   endgenerate

endmodule

// File: rtl/rtt_counter.sv
`timescale 1ns/1ps
module rtt_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         wrap,
   output logic [W-1:0] cnt_q
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step) begin
         if (wrap) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end

endmodule

// File: rtl/reload_tick_timer.sv
`timescale 1ns/1ps
module reload_tick_timer
   import rtt_pkg::*;
#(
   parameter int unsigned         CNT_W           = 32,
   parameter logic [CNT_W-1:0]    RELOAD_INIT     = '1,
   parameter bit                  BUFFERED_RELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             preload_en,
   input  logic             upd_dis,
   input  logic             ovf_only,
   input  logic             irq_en,
   input  logic             ug_req,
   input  logic             flag_clr,
   input  logic             reload_wr,
   input  logic [CNT_W-1:0] reload_wdata,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt_val,
   output logic [CNT_W-1:0] reload_preload,
   output logic [CNT_W-1:0] reload_active,
   output logic             run_status,
   output logic             working_status,
   output logic             ug_busy,
   output logic             ug_done,
   output logic             upd_flag,
   output logic             upd_evt,
   output logic             irq
);

   generate
      if (CNT_W < RTT_MIN_W || CNT_W > RTT_MAX_W) begin : g_bad_width
         $error("reload_tick_timer: CNT_W out of supported range");
      end
   endgenerate

   rtt_ctrl_t ctrl;
   rtt_src_e  src;
   logic      step;
   logic      at_match;
   logic      sw_eff;
   logic      ovf_hit;
   logic      flag_q;

   assign ctrl.preload_en = preload_en;
   assign ctrl.upd_dis    = upd_dis;
   assign ctrl.ovf_only   = ovf_only;

   rtt_runctl u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .stop_req  (stop_req),
      .tick_en   (tick_en),
      .run_q     (run_status),
      .step      (step)
   );

   rtt_swupd u_sw (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (ug_req),
      .busy_q (ug_busy),
      .done_q (ug_done)
   );

   // Software update is effective only when neither gate blocks it.
   assign sw_eff   = ug_busy & ~ctrl.upd_dis & ~ctrl.ovf_only;
   assign at_match = (cnt_val == reload_active);
   // An overflow needs the counter to advance on its own this cycle.
   assign ovf_hit  = step & at_match & ~cnt_wr & ~sw_eff;

   always_comb begin
      src = SRC_NONE;
      if (sw_eff) begin
         src = SRC_SW;
      end else if (ovf_hit && !ctrl.upd_dis) begin
         src = SRC_OVF;
      end
   end

   assign upd_evt = (src != SRC_NONE);

   rtt_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sw_eff),
      .load     (cnt_wr),
      .load_val (cnt_wdata),
      .step     (step),
      .wrap     (at_match),
      .cnt_q    (cnt_val)
   );

   rtt_reload #(
      .W        (CNT_W),
      .INIT     (RELOAD_INIT),
      .BUFFERED (BUFFERED_RELOAD)
   ) u_rld (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reload_wr),
      .wdata      (reload_wdata),
      .preload_en (ctrl.preload_en),
      .xfer       (upd_evt),
      .preload_q  (reload_preload),
      .active_q   (reload_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (upd_evt) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

   assign upd_flag       = flag_q;
   assign irq            = flag_q & irq_en;
   assign working_status = step;

endmodule

// File: rtl/rtt_checker.sv
`timescale 1ns/1ps
module rtt_checker #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick_en,
   input logic         run_status,
   input logic [W-1:0] cnt_val,
   input logic [W-1:0] reload_active,
   input logic         preload_en,
   input logic         upd_dis,
   input logic         upd_evt,
   input logic         upd_flag,
   input logic         irq_en,
   input logic         irq,
   input logic         ug_req,
   input logic         ug_busy,
   input logic         ug_done,
   input logic         cnt_wr
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_status && tick_en && !cnt_wr && !ug_busy && cnt_val != reload_active)
      |=> cnt_val == $past(cnt_val) + ONE);

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_status && tick_en && !cnt_wr && !ug_busy && cnt_val == reload_active)
      |=> cnt_val == '0);

   p_no_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      upd_dis |-> !upd_evt);

   p_hold_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_dis && preload_en) |=> $stable(reload_active));

   p_busy_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ug_busy |=> !ug_busy);

   p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |=> upd_flag);

   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   p_done_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ug_req && !ug_busy) |=> !ug_done);

   p_stopped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_status && !cnt_wr && !ug_busy) |=> $stable(cnt_val));

endmodule

bind reload_tick_timer rtt_checker #(.W(CNT_W)) u_rtt_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tick_en       (tick_en),
   .run_status    (run_status),
   .cnt_val       (cnt_val),
   .reload_active (reload_active),
   .preload_en    (preload_en),
   .upd_dis       (upd_dis),
   .upd_evt       (upd_evt),
   .upd_flag      (upd_flag),
   .irq_en        (irq_en),
   .irq           (irq),
   .ug_req        (ug_req),
   .ug_busy       (ug_busy),
   .ug_done       (ug_done),
   .cnt_wr        (cnt_wr)
);

// File: tb/reload_tick_timer_bench.sv
`timescale 1ns/1ps
module reload_tick_timer_bench;

   localparam int W = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         tick_en = 1'b1, start_req = 1'b0, stop_req = 1'b0;
   logic         preload_en = 1'b0, upd_dis = 1'b0, ovf_only = 1'b0;
   logic         irq_en = 1'b0, ug_req = 1'b0, flag_clr = 1'b0;
   logic         reload_wr = 1'b0, cnt_wr = 1'b0;
   logic [W-1:0] reload_wdata = '0, cnt_wdata = '0;
   logic [W-1:0] cnt_val, reload_preload, reload_active;
   logic         run_status, working_status, ug_busy, ug_done, upd_flag, upd_evt, irq;

   reload_tick_timer u_reload_tick_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start_req(start_req),
      .stop_req(stop_req), .preload_en(preload_en), .upd_dis(upd_dis),
      .ovf_only(ovf_only), .irq_en(irq_en), .ug_req(ug_req), .flag_clr(flag_clr),
      .reload_wr(reload_wr), .reload_wdata(reload_wdata), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata), .cnt_val(cnt_val), .reload_preload(reload_preload),
      .reload_active(reload_active), .run_status(run_status),
      .working_status(working_status), .ug_busy(ug_busy), .ug_done(ug_done),
      .upd_flag(upd_flag), .upd_evt(upd_evt), .irq(irq)
   );

   typedef enum int {S_CNT, S_ACT, S_PRE, S_FLAG, S_IRQ, S_DONE, S_RUN, S_WORK, S_BUSY, S_EVT} sel_e;
   typedef struct { sel_e sel; logic [W-1:0] exp; string req; } item_t;

   item_t q[$];
   int    total = 0;
   int    bad   = 0;
   bit    finished = 1'b0;

   function automatic logic [W-1:0] observe(sel_e s);
      case (s)
         S_CNT:  return cnt_val;
         S_ACT:  return reload_active;
         S_PRE:  return reload_preload;
         S_FLAG: return W'(upd_flag);
         S_IRQ:  return W'(irq);
         S_DONE: return W'(ug_done);
         S_RUN:  return W'(run_status);
         S_WORK: return W'(working_status);
         S_BUSY: return W'(ug_busy);
         default: return W'(upd_evt);
      endcase
   endfunction

   // Driver side: queue an expectation for the state after the current edge.
   task automatic chk(sel_e s, logic [W-1:0] e, string r);
      item_t it;
      it.sel = s;
      it.exp = e;
      it.req = r;
      q.push_back(it);
   endtask

   // Monitor: compares shortly after each edge, away from input changes.
   always @(posedge clk) begin
      item_t it;
      logic [W-1:0] act;
      #1;
      while (q.size() > 0) begin
         it  = q.pop_front();
         act = observe(it.sel);
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", it.req, it.sel.name(), act, it.exp, $time);
         end
      end
   end

   task automatic edge_n(int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      chk(S_CNT, 0, "R9"); chk(S_ACT, '1, "R9"); chk(S_PRE, '1, "R9");
      chk(S_FLAG, 0, "R9"); chk(S_RUN, 0, "R9"); chk(S_DONE, 1, "R9");
      chk(S_BUSY, 0, "R9"); chk(S_IRQ, 0, "R9");

      // R3 immediate reload
      @(negedge clk); reload_wr = 1; reload_wdata = 4;
      @(posedge clk); chk(S_ACT, 4, "R3"); chk(S_PRE, 4, "R3");
      @(negedge clk); reload_wr = 0; start_req = 1;
      @(posedge clk); chk(S_RUN, 1, "R10"); chk(S_CNT, 0, "R1"); chk(S_WORK, 1, "R10");
      @(negedge clk); start_req = 0;
      @(posedge clk); chk(S_CNT, 1, "R1");
      edge_n(3); chk(S_CNT, 4, "R1"); chk(S_EVT, 1, "R2");
      @(posedge clk); chk(S_CNT, 0, "R2"); chk(S_FLAG, 1, "R6"); chk(S_IRQ, 0, "R7");

      // R7 mask, R6 clear, R10 stop
      @(negedge clk); irq_en = 1;
      @(posedge clk); chk(S_IRQ, 1, "R7");
      @(negedge clk); flag_clr = 1;
      @(posedge clk); chk(S_FLAG, 0, "R6"); chk(S_IRQ, 0, "R7");
      @(negedge clk); flag_clr = 0; stop_req = 1;
      @(posedge clk); chk(S_RUN, 0, "R10"); chk(S_WORK, 0, "R10"); chk(S_CNT, 3, "R1");
      @(negedge clk); stop_req = 0;
      edge_n(3); chk(S_CNT, 3, "R10");

      // R3 buffered reload, R5 software update, R8 done handshake
      @(negedge clk); preload_en = 1; reload_wr = 1; reload_wdata = 2;
      @(posedge clk); chk(S_PRE, 2, "R3"); chk(S_ACT, 4, "R3");
      @(negedge clk); reload_wr = 0; ug_req = 1;
      @(posedge clk); chk(S_BUSY, 1, "R5"); chk(S_DONE, 0, "R8"); chk(S_EVT, 1, "R5");
      @(negedge clk); ug_req = 0;
      @(posedge clk); chk(S_CNT, 0, "R5"); chk(S_ACT, 2, "R3"); chk(S_FLAG, 1, "R6");
      chk(S_BUSY, 0, "R5"); chk(S_DONE, 0, "R8");
      @(posedge clk); chk(S_DONE, 1, "R8");

      // R5 overflow-only source, R11 counter write
      @(negedge clk); flag_clr = 1; ovf_only = 1; cnt_wr = 1; cnt_wdata = 7;
      reload_wr = 1; reload_wdata = 9;
      @(posedge clk); chk(S_CNT, 7, "R11"); chk(S_FLAG, 0, "R6"); chk(S_PRE, 9, "R3"); chk(S_ACT, 2, "R3");
      @(negedge clk); flag_clr = 0; cnt_wr = 0; reload_wr = 0; ug_req = 1;
      @(posedge clk); chk(S_BUSY, 1, "R5"); chk(S_EVT, 0, "R5");
      @(negedge clk); ug_req = 0;
      @(posedge clk); chk(S_CNT, 7, "R5"); chk(S_FLAG, 0, "R5"); chk(S_ACT, 2, "R5");
      @(posedge clk); chk(S_DONE, 1, "R8");

      // R4 update disable
      @(negedge clk); ovf_only = 0; upd_dis = 1; ug_req = 1;
      @(posedge clk);
      @(negedge clk); ug_req = 0;
      @(posedge clk); chk(S_CNT, 7, "R4"); chk(S_ACT, 2, "R4"); chk(S_FLAG, 0, "R4");
      @(negedge clk); cnt_wr = 1; cnt_wdata = 1;
      @(posedge clk); chk(S_CNT, 1, "R11");
      @(negedge clk); cnt_wr = 0; start_req = 1;
      @(posedge clk); chk(S_RUN, 1, "R10"); chk(S_CNT, 1, "R10");
      @(negedge clk); start_req = 0;
      @(posedge clk); chk(S_CNT, 2, "R1"); chk(S_EVT, 0, "R4");
      @(posedge clk); chk(S_CNT, 0, "R4"); chk(S_FLAG, 0, "R4"); chk(S_ACT, 2, "R4");
      @(negedge clk); upd_dis = 0;
      @(posedge clk); chk(S_CNT, 1, "R1");
      @(posedge clk); chk(S_EVT, 1, "R2");
      @(posedge clk); chk(S_CNT, 0, "R2"); chk(S_ACT, 9, "R3"); chk(S_FLAG, 1, "R6");

      // R11 priorities
      @(negedge clk); cnt_wr = 1; cnt_wdata = 5;
      @(posedge clk); chk(S_CNT, 5, "R11");
      @(negedge clk); cnt_wr = 0;
      @(posedge clk); chk(S_CNT, 6, "R1");
      @(negedge clk); ug_req = 1;
      @(posedge clk); chk(S_CNT, 7, "R1");
      @(negedge clk); ug_req = 0; cnt_wr = 1; cnt_wdata = 100;
      @(posedge clk); chk(S_CNT, 0, "R11");

      // R1 tick gating
      @(negedge clk); cnt_wr = 0; tick_en = 0;
      edge_n(3); chk(S_CNT, 0, "R1"); chk(S_WORK, 0, "R10"); chk(S_RUN, 1, "R10");
      @(negedge clk); tick_en = 1;
      @(posedge clk); chk(S_CNT, 1, "R1");

      // R10 stop beats start
      @(negedge clk); start_req = 1; stop_req = 1;
      @(posedge clk); chk(S_RUN, 0, "R10");

      // R2 wrap at all-ones reload
      @(negedge clk); start_req = 0; stop_req = 0; preload_en = 0;
      reload_wr = 1; reload_wdata = '1; cnt_wr = 1; cnt_wdata = 32'hFFFF_FFFE;
      @(posedge clk); chk(S_ACT, '1, "R3"); chk(S_CNT, 32'hFFFF_FFFE, "R11");
      @(negedge clk); reload_wr = 0; cnt_wr = 0; start_req = 1;
      @(posedge clk); chk(S_CNT, 32'hFFFF_FFFE, "R10");
      @(negedge clk); start_req = 0;
      @(posedge clk); chk(S_CNT, '1, "R1"); chk(S_EVT, 1, "R2");
      @(posedge clk); chk(S_CNT, 0, "R2");

      @(negedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule